// File: doc/BRIEF.md
# Next-Fetch-Address Predictor with Branch Target Buffer

This block sits in the fetch stage of a pipelined core and chooses, every cycle, the address to fetch next. It looks up the current program counter in a direct-mapped branch target buffer. Each entry holds a valid bit, an address tag, a branch target and a 2-bit saturating direction counter. When the lookup hits and the counter leans taken, the stored target is offered as the next fetch address. In every other case the sequential address, PC plus the instruction size, is offered.

The execute stage reports each resolved branch on an update port. It gives the branch PC, whether the branch was taken and the actual target. A resolved branch that hits in the table trains that entry's counter. A taken branch that misses claims the entry for itself. The lookup path is purely combinational. Updates take effect on the rising clock edge.

Top module: `btb_next_pc`

## Requirements
- R1: The table index is PC[7:2] and the tag is PC[31:8] (default parameters: 64 entries, 32-bit addresses, 4-byte instructions). A lookup hits only when the indexed entry is valid and its stored tag equals the PC's tag.
- R2: `next_pc` equals the stored target when the lookup hits and the counter's upper bit is 1 (encodings 10 and 11). In every other case it equals `fetch_pc + 4`.
- R3: A taken resolve writes the actual target into the entry it hits or allocates. Later lookups of that branch return that target until it is rewritten or the entry is replaced.
- R4: Each resolve that hits trains the entry's counter. A taken outcome increments it and holds it at 11. A not-taken outcome decrements it and holds it at 00.
- R5: From a strong state (11 or 00), a single contrary outcome does not change the prediction.
- R6: A newly allocated entry starts with its counter at weakly taken (10).
- R7: A taken resolve that misses allocates the indexed entry, writing the valid bit, tag, target and counter. It replaces any other branch that shared the index.
- R8: A not-taken resolve that misses leaves the table unchanged.
- R9: `rst_n` is synchronous and active low. It clears every valid bit, so all lookups miss until an entry is allocated.
- R10: When a lookup and a resolve address the same entry in the same cycle, the lookup sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | 32 | Address of the instruction being fetched |
| next_pc | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is presented this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_target | input | 32 | Actual target of the resolved branch |

## Verification
The bench walks one entry through every counter state in both directions. If the counter wrapped instead of saturating, a branch held at 11 would fall to a not-taken prediction, and a branch held at 00 would jump to taken. Two branches that share an index but differ in tag are used together. This checks that a tag mismatch gives the sequential address, that a taken miss evicts the old branch, and that a not-taken miss leaves the old branch in place; a design that matched on index alone would return the wrong target. A lookup and an allocation to the same entry are issued in the same cycle to show the old contents win. A mid-run reset shows that it drops every stored branch.

// File: rtl/btb_pkg.sv
// Shared types for the next-fetch-address predictor.
// Assumes the 2-bit counter encoding in which the upper bit is the prediction.
package btb_pkg;

    typedef enum logic [1:0] {
        DIR_STRONG_NT = 2'b00,
        DIR_WEAK_NT   = 2'b01,
        DIR_WEAK_T    = 2'b10,
        DIR_STRONG_T  = 2'b11
    } dir_ctr_t;

endpackage

// File: rtl/btb_sat_ctr.sv
// Next-state logic for one 2-bit saturating direction counter.
// Assumes the caller applies the result only when a resolved branch hits.
module btb_sat_ctr
    import btb_pkg::*;
(
    input  dir_ctr_t cur_ctr,
    input  logic     outcome_taken,
    output dir_ctr_t nxt_ctr
);

    // Step toward the outcome, holding at the end states.
    always_comb begin
        unique case (cur_ctr)
            DIR_STRONG_NT: nxt_ctr = outcome_taken ? DIR_WEAK_NT  : DIR_STRONG_NT;
            DIR_WEAK_NT:   nxt_ctr = outcome_taken ? DIR_WEAK_T   : DIR_STRONG_NT;
            DIR_WEAK_T:    nxt_ctr = outcome_taken ? DIR_STRONG_T : DIR_WEAK_NT;
            default:       nxt_ctr = outcome_taken ? DIR_STRONG_T : DIR_WEAK_T;
        endcase
    end

endmodule

// File: rtl/btb_table.sv
// Direct-mapped entry store with one combinational lookup port and one
// training port. Hits train the counter; taken misses allocate at weakly taken.
// Assumes index and tag are already split from the address by the caller.
module btb_table
    import btb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 24,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup port
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output dir_ctr_t          lk_ctr,
    output logic [ADDR_W-1:0] lk_target,
    // training port
    input  logic              up_valid,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic [TAG_W-1:0]  up_tag,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    dir_ctr_t           ctr_q [ENTRIES];

    logic     up_hit;
    dir_ctr_t up_ctr_nxt;

    // Lookup reads the registered contents, so same-cycle updates are not seen.
    always_comb begin
        lk_hit    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_ctr    = ctr_q[lk_idx];
        lk_target = tgt_q[lk_idx];
    end

    // Hit detection for the resolved branch.
    assign up_hit = vld_q[up_idx] && (tag_q[up_idx] == up_tag);

    btb_sat_ctr u_ctr (
        .cur_ctr       (ctr_q[up_idx]),
        .outcome_taken (up_taken),
        .nxt_ctr       (up_ctr_nxt)
    );

    // Train on a hit, allocate on a taken miss, clear valid bits on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (up_valid) begin
            if (up_hit) begin
                ctr_q[up_idx] <= up_ctr_nxt;
                if (up_taken) tgt_q[up_idx] <= up_target;
            end else if (up_taken) begin
                vld_q[up_idx] <= 1'b1;
                tag_q[up_idx] <= up_tag;
                tgt_q[up_idx] <= up_target;
                ctr_q[up_idx] <= DIR_WEAK_T;
            end
        end
    end

    // R4: taken outcome on a strong-taken entry stays at 11
    a_r4_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && up_taken && ctr_q[up_idx] == DIR_STRONG_T)
        |=> ctr_q[$past(up_idx)] == DIR_STRONG_T);

    // R4: not-taken outcome on a strong-not-taken entry stays at 00
    a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && !up_taken && ctr_q[up_idx] == DIR_STRONG_NT)
        |=> ctr_q[$past(up_idx)] == DIR_STRONG_NT);

    // R5: one contrary outcome from strong taken keeps the taken prediction
    a_r5_strong_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && !up_taken && ctr_q[up_idx] == DIR_STRONG_T)
        |=> ctr_q[$past(up_idx)][1]);

    // R6: allocation leaves a valid entry at weakly taken
    a_r6_alloc_weak: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_hit && up_taken)
        |=> vld_q[$past(up_idx)] && ctr_q[$past(up_idx)] == DIR_WEAK_T);

    // R8: not-taken miss does not change any valid bit
    a_r8_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_hit && !up_taken) |=> vld_q == $past(vld_q));

endmodule

// File: rtl/btb_next_pc.sv
// Fetch-stage next-address predictor. Splits the fetch and resolve PCs into
// index and tag, looks up the entry store and selects target or PC + size.
// Assumes INSN_BYTES and ENTRIES are powers of two.
module btb_next_pc
    import btb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 64,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] next_pc,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target
);

    localparam int OFS_W = $clog2(INSN_BYTES);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic              lk_hit;
    dir_ctr_t          lk_ctr;
    logic [ADDR_W-1:0] lk_target;
    logic [ADDR_W-1:0] seq_pc;

    // Address split for both ports.
    always_comb begin
        lk_idx = fetch_pc[OFS_W +: IDX_W];
        lk_tag = fetch_pc[ADDR_W-1 -: TAG_W];
        up_idx = res_pc[OFS_W +: IDX_W];
        up_tag = res_pc[ADDR_W-1 -: TAG_W];
    end

    btb_table #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .ADDR_W  (ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .lk_hit    (lk_hit),
        .lk_ctr    (lk_ctr),
        .lk_target (lk_target),
        .up_valid  (res_valid),
        .up_idx    (up_idx),
        .up_tag    (up_tag),
        .up_taken  (res_taken),
        .up_target (res_target)
    );

    // Redirect only on a hit that leans taken.
    always_comb begin
        seq_pc  = fetch_pc + ADDR_W'(INSN_BYTES);
        next_pc = (lk_hit && lk_ctr[1]) ? lk_target : seq_pc;
    end

    // R2: a lookup that leans not taken always falls through sequentially
    a_r2_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_ctr[1]) |-> next_pc == fetch_pc + ADDR_W'(INSN_BYTES));

endmodule

// File: tb/btb_next_pc_tb_top.sv
module btb_next_pc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = 32'h0;
    logic [31:0] next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = 32'h0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = 32'h0;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    btb_next_pc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .next_pc    (next_pc),
        .res_valid  (res_valid),
        .res_pc     (res_pc),
        .res_taken  (res_taken),
        .res_target (res_target)
    );

    task automatic check_next(input string req, input logic [31:0] pc, input logic [31:0] exp);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        n_checks++;
        if (next_pc !== exp) begin
            n_errors++;
            $display("FAIL %s pc=%h actual=%h expected=%h", req, pc, next_pc, exp);
        end
    endtask

    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        check_next("R9", 32'h100, 32'h104);
        check_next("R2", 32'h300, 32'h304);
    endtask

    task automatic t_notaken_miss();
        resolve(32'h200, 1'b0, 32'h900);
        check_next("R8", 32'h200, 32'h204);
    endtask

    task automatic t_allocate();
        resolve(32'h300, 1'b1, 32'h1000);
        check_next("R7", 32'h300, 32'h1000);
        check_next("R3", 32'h300, 32'h1000);
    endtask

    task automatic t_weak_init();
        resolve(32'h300, 1'b0, 32'h0);          // 10 -> 01
        check_next("R6", 32'h300, 32'h304);
        resolve(32'h300, 1'b1, 32'h1000);       // 01 -> 10
        check_next("R4", 32'h300, 32'h1000);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 4; i++) resolve(32'h300, 1'b1, 32'h1000); // held at 11
        resolve(32'h300, 1'b0, 32'h0);          // 11 -> 10
        check_next("R5", 32'h300, 32'h1000);
        resolve(32'h300, 1'b0, 32'h0);          // 10 -> 01
        check_next("R4", 32'h300, 32'h304);
        for (int i = 0; i < 3; i++) resolve(32'h300, 1'b0, 32'h0);     // held at 00
        resolve(32'h300, 1'b1, 32'h1000);       // 00 -> 01
        check_next("R5", 32'h300, 32'h304);
        resolve(32'h300, 1'b1, 32'h1000);       // 01 -> 10
        check_next("R4", 32'h300, 32'h1000);
    endtask

    task automatic t_tag_alias();
        check_next("R1", 32'h400, 32'h404);
        resolve(32'h700, 1'b0, 32'h0);          // same index, miss, not taken
        check_next("R8", 32'h300, 32'h1000);
        check_next("R1", 32'h700, 32'h704);
    endtask

    task automatic t_replace();
        resolve(32'h400, 1'b1, 32'h2000);
        check_next("R7", 32'h400, 32'h2000);
        check_next("R7", 32'h300, 32'h304);
        resolve(32'h400, 1'b0, 32'h0);          // 10 -> 01
        check_next("R6", 32'h400, 32'h404);
        resolve(32'h400, 1'b1, 32'h2000);       // 01 -> 10
    endtask

    task automatic t_target_update();
        resolve(32'h400, 1'b1, 32'h2400);
        check_next("R3", 32'h400, 32'h2400);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        fetch_pc = 32'h500;
        res_valid = 1'b1; res_pc = 32'h500; res_taken = 1'b1; res_target = 32'h3000;
        #1;
        n_checks++;
        if (next_pc !== 32'h504) begin
            n_errors++;
            $display("FAIL R10 actual=%h expected=%h", next_pc, 32'h504);
        end
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        n_checks++;
        if (next_pc !== 32'h3000) begin
            n_errors++;
            $display("FAIL R10 actual=%h expected=%h", next_pc, 32'h3000);
        end
    endtask

    task automatic t_midrun_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_next("R9", 32'h500, 32'h504);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_notaken_miss();
        t_allocate();
        t_weak_init();
        t_saturate();
        t_tag_alias();
        t_replace();
        t_target_update();
        t_same_cycle();
        t_midrun_reset();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule